// File: doc/BRIEF.md
# Phase-Fraction to Delay-Tap Converter

This block turns a requested clock phase shift into a tap count for a delay line. A calibration loop elsewhere measures how many taps span one clock period and keeps that number current. The block takes it as the input `taps_per_period` and scales the stored request against it on every cycle. When the period count drifts, the output follows on the next cycle without any new request.

Two interpretations of the stored request are selectable. In angle mode the request is a signed fraction of a period in steps of 1/256, and it may reach one full period either way. In direct mode the request is a signed raw tap count, limited to half a period of taps either way. The request is written whole through a load port, or nudged one unit at a time through a step port. Writes beyond the limit saturate and raise a sticky overflow flag. Each accepted step is acknowledged by a one-cycle done pulse.

Top module: `phase_tap_conv`

## Requirements
- R1: While reset is high and in the first cycle after it, the stored request is zero, and `tap_mag`, `tap_back`, `tap_valid`, `step_done` and `ovf_flag` are all 0.
- R2: With `mode`=0 (angle mode), `tap_mag` is floor(min(|req|,256) × `taps_per_period` / 256) and `tap_back` is 1 exactly when req is negative. The outputs are registered and appear one cycle after the request register takes its new value.
- R3: With `mode`=1 (direct mode), `tap_mag` is min(|req|, floor(`taps_per_period`/2)) with no scaling, and `tap_back` is the sign of req.
- R4: A load (`req_load`=1) stores `req_value`, a signed two's-complement number. If its magnitude exceeds the mode limit (256 in angle mode, floor(`taps_per_period`/2) in direct mode), the limit is stored with the request's sign instead and `ovf_flag` is set.
- R5: Once `ovf_flag` is set, it stays set until reset.
- R6: `step_en`=1 with `step_dir`=1 adds one to the stored request, and with `step_dir`=0 subtracts one. A step that would pass the mode limit leaves the request at the limit and sets `ovf_flag`.
- R7: When `req_load` and `step_en` are both high in the same cycle, the load is applied and the step is ignored. The ignored step produces no `step_done` pulse.
- R8: `step_done` is a one-cycle pulse two cycles after an accepted step, which is one cycle after the tap output reflecting it. It is raised only if `tap_valid` was 1 in that tap-output cycle.
- R9: If `cal_done`=0 or `taps_per_period`=0, then on the next cycle `tap_mag`=0, `tap_back`=0 and `tap_valid`=0. The stored request is retained and reappears once calibration is good.
- R10: A change of `taps_per_period` alone changes `tap_mag` on the next cycle to the value recomputed from the stored request.
- R11: The `mode` input changes only how the stored request is read. Switching mode with no write recomputes the output from the same request under the new rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration loop has a valid period count |
| taps_per_period | input | TAP_W | Calibrated taps spanning one clock period |
| mode | input | 1 | 0 = angle (1/256 period units), 1 = direct taps |
| req_load | input | 1 | Write `req_value` into the request register |
| req_value | input | TAP_W+1 | Signed request for a load |
| step_en | input | 1 | Move the request by one unit |
| step_dir | input | 1 | 1 = increment, 0 = decrement |
| tap_mag | output | TAP_W | Tap count magnitude |
| tap_back | output | 1 | 1 = shift backward (negative request) |
| tap_valid | output | 1 | Tap output is based on a good calibration |
| step_done | output | 1 | Accepted step has reached the output |
| ovf_flag | output | 1 | Sticky: a write was saturated |

## Verification
Two writes can land on the request register in the same cycle: a load and a step. The bench raises both together in directed cases, including one with a load that saturates. It checks that the loaded value alone reaches the taps and that no done pulse follows. A step can also coincide with a new period count. The random phase changes `taps_per_period` and `mode` on the very cycle of a step or a load. Each result is compared with a bench model that saturates against the period count of that cycle. The model also confirms that the later output is rescaled with the new count.

// File: rtl/phase_tap_pkg.sv
package phase_tap_pkg;

    // Interpretation of the stored request
    typedef enum logic {
        SHIFT_ANGLE  = 1'b0,
        SHIFT_DIRECT = 1'b1
    } shift_mode_e;

    // Angle requests are in 1/2**FRAC_BITS of a period
    localparam int FRAC_BITS = 8;
    localparam int FULL_TURN = 1 << FRAC_BITS;

    // Registered tap result
    typedef struct packed {
        logic valid;
        logic back;
    } tap_flags_t;

endpackage

// File: rtl/ptc_req_reg.sv
module ptc_req_reg
    import phase_tap_pkg::*;
#(
    parameter int REQ_W = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [REQ_W-1:0]        limit,
    input  logic                    load,
    input  logic signed [REQ_W-1:0] load_val,
    input  logic                    step_en,
    input  logic                    step_dir,
    output logic signed [REQ_W-1:0] req,
    output logic                    ovf,
    output logic                    step_acc
);
    localparam int EXT_W = REQ_W + 1;

    logic signed [EXT_W-1:0] cand;
    logic        [EXT_W-1:0] cand_mag;
    logic                    write_en;
    logic                    over;
    logic signed [REQ_W-1:0] next_req;
    logic        [REQ_W-1:0] neg_limit;

    always_comb begin
        write_en = load | step_en;
        if (load) begin
            cand = EXT_W'(load_val);
        end else if (step_dir) begin
            cand = EXT_W'(req) + EXT_W'(1);
        end else begin
            cand = EXT_W'(req) - EXT_W'(1);
        end
        cand_mag  = cand[EXT_W-1] ? EXT_W'(-cand) : EXT_W'(cand);
        over      = cand_mag > {1'b0, limit};
        neg_limit = ~limit + REQ_W'(1);
        if (!over) begin
            next_req = cand[REQ_W-1:0];
        end else if (cand[EXT_W-1]) begin
            next_req = neg_limit;
        end else begin
            next_req = limit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= '0;
            ovf      <= 1'b0;
            step_acc <= 1'b0;
        end else begin
            step_acc <= step_en & ~load;
            if (write_en) begin
                req <= next_req;
                if (over) begin
                    ovf <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ptc_scaler.sv
module ptc_scaler
    import phase_tap_pkg::*;
#(
    parameter int TAP_W = 10,
    parameter int REQ_W = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  shift_mode_e             mode,
    input  logic                    cal_ok,
    input  logic [TAP_W-1:0]        tpp,
    input  logic [REQ_W-1:0]        limit,
    input  logic signed [REQ_W-1:0] req,
    output logic [TAP_W-1:0]        tap_mag,
    output tap_flags_t              flags
);
    localparam int PROD_W = REQ_W + TAP_W;

    logic [REQ_W-1:0]  req_mag;
    logic [REQ_W-1:0]  clipped;
    logic [PROD_W-1:0] product;
    logic [TAP_W-1:0]  mag_next;

    always_comb begin
        req_mag = req[REQ_W-1] ? REQ_W'(-req) : REQ_W'(req);
        clipped = (req_mag > limit) ? limit : req_mag;
        // full-width product, then truncate toward the lower tap
        product = PROD_W'(clipped) * PROD_W'(tpp);
        if (mode == SHIFT_DIRECT) begin
            mag_next = TAP_W'(clipped);
        end else begin
            mag_next = TAP_W'(product >> FRAC_BITS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_mag <= '0;
            flags   <= '0;
        end else if (cal_ok) begin
            tap_mag     <= mag_next;
            flags.valid <= 1'b1;
            flags.back  <= req[REQ_W-1];
        end else begin
            tap_mag <= '0;
            flags   <= '0;
        end
    end
endmodule

// File: rtl/ptc_done_pipe.sv
module ptc_done_pipe (
    input  logic clk,
    input  logic rst,
    input  logic step_acc,
    input  logic tap_valid,
    output logic step_done
);
    logic acc_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_d1    <= 1'b0;
            step_done <= 1'b0;
        end else begin
            acc_d1    <= step_acc;
            step_done <= acc_d1 & tap_valid;
        end
    end
endmodule

// File: rtl/phase_tap_conv.sv
module phase_tap_conv
    import phase_tap_pkg::*;
#(
    parameter int TAP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_done,
    input  logic [TAP_W-1:0]        taps_per_period,
    input  logic                    mode,
    input  logic                    req_load,
    input  logic signed [TAP_W:0]   req_value,
    input  logic                    step_en,
    input  logic                    step_dir,
    output logic [TAP_W-1:0]        tap_mag,
    output logic                    tap_back,
    output logic                    tap_valid,
    output logic                    step_done,
    output logic                    ovf_flag
);
    localparam int REQ_W = TAP_W + 1;

    shift_mode_e             mode_e;
    logic [REQ_W-1:0]        limit;
    logic                    cal_ok;
    logic signed [REQ_W-1:0] req;
    logic                    step_acc;
    tap_flags_t              flags;

    always_comb begin
        mode_e = shift_mode_e'(mode);
        cal_ok = cal_done && (taps_per_period != '0);
        if (mode_e == SHIFT_DIRECT) begin
            limit = REQ_W'(taps_per_period >> 1);
        end else begin
            limit = REQ_W'(FULL_TURN);
        end
    end

    ptc_req_reg #(.REQ_W(REQ_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .limit    (limit),
        .load     (req_load),
        .load_val (req_value),
        .step_en  (step_en),
        .step_dir (step_dir),
        .req      (req),
        .ovf      (ovf_flag),
        .step_acc (step_acc)
    );

    ptc_scaler #(.TAP_W(TAP_W), .REQ_W(REQ_W)) u_scale (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_e),
        .cal_ok  (cal_ok),
        .tpp     (taps_per_period),
        .limit   (limit),
        .req     (req),
        .tap_mag (tap_mag),
        .flags   (flags)
    );

    assign tap_valid = flags.valid;
    assign tap_back  = flags.back;

    ptc_done_pipe u_done (
        .clk       (clk),
        .rst       (rst),
        .step_acc  (step_acc),
        .tap_valid (tap_valid),
        .step_done (step_done)
    );
endmodule

// File: rtl/phase_tap_conv_chk.sv
module phase_tap_conv_chk #(
    parameter int TAP_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cal_done,
    input logic [TAP_W-1:0] taps_per_period,
    input logic [TAP_W-1:0] tap_mag,
    input logic             tap_back,
    input logic             tap_valid,
    input logic             step_done,
    input logic             ovf_flag
);
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !tap_valid |-> (tap_mag == '0 && !tap_back)); // R9

    AST_VALID_TRACKS_CAL: assert property (@(posedge clk) disable iff (rst)
        (cal_done && taps_per_period != '0) |=> tap_valid); // R9

    AST_INVALID_TRACKS_CAL: assert property (@(posedge clk) disable iff (rst)
        !(cal_done && taps_per_period != '0) |=> !tap_valid); // R9

    AST_MAG_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tap_mag <= $past(taps_per_period))); // R2

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        step_done |-> $past(tap_valid)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R5
endmodule

bind phase_tap_conv phase_tap_conv_chk #(.TAP_W(TAP_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cal_done        (cal_done),
    .taps_per_period (taps_per_period),
    .tap_mag         (tap_mag),
    .tap_back        (tap_back),
    .tap_valid       (tap_valid),
    .step_done       (step_done),
    .ovf_flag        (ovf_flag)
);

// File: tb/phase_tap_conv_tb.sv
module phase_tap_conv_tb;
    localparam int TAP_W = 10;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  cal_done;
    logic [TAP_W-1:0]      taps_per_period;
    logic                  mode;
    logic                  req_load;
    logic signed [TAP_W:0] req_value;
    logic                  step_en;
    logic                  step_dir;
    logic [TAP_W-1:0]      tap_mag;
    logic                  tap_back;
    logic                  tap_valid;
    logic                  step_done;
    logic                  ovf_flag;

    int nvec = 0;
    int nerr = 0;

    // model state
    int  m_req = 0;
    bit  m_ovf = 0;

    always #5 clk = ~clk;

    phase_tap_conv #(.TAP_W(TAP_W)) u_dut (
        .clk(clk), .rst(rst), .cal_done(cal_done),
        .taps_per_period(taps_per_period), .mode(mode),
        .req_load(req_load), .req_value(req_value),
        .step_en(step_en), .step_dir(step_dir),
        .tap_mag(tap_mag), .tap_back(tap_back), .tap_valid(tap_valid),
        .step_done(step_done), .ovf_flag(ovf_flag)
    );

    function automatic int lim_of(input bit md, input int tp);
        return md ? (tp / 2) : 256;
    endfunction

    function automatic int exp_mag(input int r, input bit md, input int tp);
        int a;
        a = (r < 0) ? -r : r;
        if (a > lim_of(md, tp)) a = lim_of(md, tp);
        return md ? a : (a * tp) / 256;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input bit md, input int tp, input bit cd);
        bit ok;
        ok = cd && (tp != 0);
        chk({tag, " mag"},   tap_mag,   ok ? exp_mag(m_req, md, tp) : 0);
        chk({tag, " back"},  tap_back,  ok ? (m_req < 0) : 0);
        chk({tag, " valid"}, tap_valid, ok);
        chk({tag, " ovf"},   ovf_flag,  m_ovf);
    endtask

    // one operation: inputs held for one edge, outputs checked after settling
    task automatic do_op(input bit ld, input int v, input bit st, input bit dir,
                         input bit md, input int tp, input bit cd, input string tag);
        int  cand;
        int  lim;
        bit  ok;
        @(negedge clk);
        mode = md; taps_per_period = TAP_W'(tp); cal_done = cd;
        req_load = ld; req_value = (TAP_W+1)'(v); step_en = st; step_dir = dir;
        lim = lim_of(md, tp);
        if (ld || st) begin
            cand = ld ? v : (dir ? m_req + 1 : m_req - 1);
            if (cand > lim) begin cand = lim; m_ovf = 1; end
            else if (cand < -lim) begin cand = -lim; m_ovf = 1; end
            m_req = cand;
        end
        ok = cd && (tp != 0);
        @(posedge clk); @(negedge clk);
        req_load = 0; step_en = 0;
        @(posedge clk); @(negedge clk);
        check_out(tag, md, tp, cd);
        chk({tag, " done-early"}, step_done, 0);
        @(posedge clk); @(negedge clk);
        chk({tag, " done"}, step_done, (st && !ld && ok));
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_0042);
        rst = 1; cal_done = 1; taps_per_period = 10'd512; mode = 0;
        req_load = 0; req_value = '0; step_en = 0; step_dir = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs zero during reset
        chk("R1 mag in reset", tap_mag, 0);
        chk("R1 valid in reset", tap_valid, 0);
        chk("R1 ovf in reset", ovf_flag, 0);
        rst = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 first cycle mag", tap_mag, 0);
        chk("R1 first cycle done", step_done, 0);
        chk("R1 first cycle ovf", ovf_flag, 0);

        // R2: angle mode, truncating scale
        do_op(1, 100, 0, 0, 0, 512, 1, "R2 load 100/256 tpp512");
        do_op(1, -23, 0, 0, 0, 300, 1, "R2 load -23/256 tpp300");
        do_op(1, 256, 0, 0, 0, 1023, 1, "R2 full period");
        // R10: period count drifts, no new request
        do_op(0, 0, 0, 0, 0, 777, 1, "R10 tpp change");
        // R11: same request read as direct taps
        do_op(0, 0, 0, 0, 1, 777, 1, "R11 switch to direct");
        // R3: direct mode
        do_op(1, -150, 0, 0, 1, 400, 1, "R3 direct -150");
        // R6: steps
        do_op(0, 0, 1, 1, 1, 400, 1, "R6 step up");
        do_op(0, 0, 1, 0, 1, 400, 1, "R6 step down");
        do_op(1, 200, 0, 0, 1, 400, 1, "R4 direct at limit");
        chk("R4 no ovf at exact limit", ovf_flag, 0);
        do_op(0, 0, 1, 1, 1, 400, 1, "R6 step past limit");
        // R5: sticky
        do_op(1, 5, 0, 0, 0, 400, 1, "R5 ovf stays");
        // R7: load and step collide
        do_op(1, 40, 1, 1, 0, 256, 1, "R7 load wins");
        do_op(1, -300, 1, 0, 0, 256, 1, "R7 saturating load wins");
        // R4: angle over range
        do_op(1, -1024, 0, 0, 0, 600, 1, "R4 angle saturate");
        // R9: calibration missing keeps request
        do_op(1, 64, 0, 0, 0, 600, 0, "R9 cal_done low");
        do_op(0, 0, 1, 1, 0, 600, 0, "R8 step while invalid");
        do_op(0, 0, 0, 0, 0, 0, 1, "R9 tpp zero");
        do_op(0, 0, 0, 0, 0, 600, 1, "R9 request restored");

        // reset clears everything including ovf
        @(negedge clk); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
        m_req = 0; m_ovf = 0;
        @(posedge clk); @(negedge clk);
        check_out("R1 after second reset", 0, 600, 1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            bit ld, st, dir, md, cd;
            int v, tp;
            ld  = ($urandom % 3) == 0;
            st  = ($urandom % 2) == 0;
            dir = $urandom % 2;
            md  = $urandom % 2;
            cd  = ($urandom % 10) != 0;
            tp  = ($urandom % 12 == 0) ? ($urandom % 3) : ($urandom % 1024);
            v   = (($urandom % 1200) - 600);
            if ($urandom % 20 == 0) v = -1024;
            do_op(ld, v, st, dir, md, tp, cd, st ? "R6 random" : "R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule